// File: doc/BRIEF.md
# Dual Complementary Dead-Time PWM Generator

This block produces two pulse-width-modulated channels, A and B, from one free-running 8-bit up-counter. The counter starts at zero, climbs to a programmable top value and then returns to zero, so the top value sets the PWM period. Each channel compares the counter with its own compare value to form an internal level. Each channel drives that level on a true output and its complement on an inverted output. The two outputs of a pair are never high together, so a pair can drive the high and low switches of a half-bridge directly.

The dead time is made by delaying only rising edges. A rising edge waits one prescaled cycle plus one fast clock, and a falling edge waits one fast clock. The counter and the dead-time stage advance only on fast-clock cycles where the prescale strobe `tick` is high. The top and compare values are written through simple write ports into buffers. The buffered values take effect only when the counter wraps, so a new setting never produces a partial period. An overflow flag records each time the counter reaches the top value, and it stays set until software clears it.

Top module: `cpwm_dual`

## Requirements
- R1: The reset `rst_n` is synchronous and active low. At every clock edge where it is low, all four PWM outputs and `ovf_flag` go low and the counter goes to 0. Both the active and the buffered top value go to 255, and both compare values go to 0.
- R2: The counter advances by one only at edges where `tick` is high, and holds its value otherwise. At a tick edge where it equals the active top value, it returns to 0 instead of advancing.
- R3: A write to the top value or to a compare value lands in a buffer. The buffer is copied into the active value only at the tick edge where the counter wraps. A write made at the same edge as a wrap waits for the following wrap.
- R4: The mode fields `mode_a` and `mode_b` are 2 bits each, with this encoding:
  - 00: the channel is off.
  - 01: a complementary pair that clears on match.
  - 10: the true output only, clearing on match.
  - 11: a complementary pair that sets on match.

  In modes 01 and 10, the channel level is set at the wrap edge and cleared at the tick edge where the counter equals the active compare value. Mode 11 uses the opposite levels. When the counter equals both top and compare at the same edge, the wrap action wins.
- R5: In mode 10, the inverted output is low from one clock after the mode is applied, and the true output keeps its dead-time behaviour.
- R6: In mode 00, both outputs of the channel are low from one clock after the mode is applied.
- R7: The true and inverted outputs of a channel are never high in the same cycle.
- R8: The true output is registered from three terms: the channel level, the level one tick earlier, and the mode enable. As a result, rising edges are delayed by one tick plus one clock and falling edges by one clock. The inverted output follows the same rule on the complement. With `tick` high every clock in mode 01, the true output is high for compare clocks per period, and the inverted output for top − compare − 1 clocks.
- R9: At a tick edge where the counter equals the active top value, `ovf_flag` goes high one clock later and stays high.
- R10: `ovf_clr` high at an edge clears `ovf_flag`. If a set is due at that same edge, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | Prescale enable strobe |
| top_wr | input | 1 | Write strobe for the top-value buffer |
| top_wdata | input | 8 | New top value |
| cmp_a_wr | input | 1 | Write strobe for the channel A compare buffer |
| cmp_a_wdata | input | 8 | New channel A compare value |
| cmp_b_wr | input | 1 | Write strobe for the channel B compare buffer |
| cmp_b_wdata | input | 8 | New channel B compare value |
| mode_a | input | 2 | Channel A output mode |
| mode_b | input | 2 | Channel B output mode |
| ovf_clr | input | 1 | Clears the overflow flag |
| ovf_flag | output | 1 | Sticky overflow flag |
| pwm_a | output | 1 | Channel A true output |
| pwm_a_n | output | 1 | Channel A inverted output |
| pwm_b | output | 1 | Channel B true output |
| pwm_b_n | output | 1 | Channel B inverted output |

## Verification
A corrupted counter or a wrongly loaded active top value shows within one period: the pulse widths change and the overflow flag rises at the wrong clock. A stale or early-loaded compare buffer moves a pulse edge in the very period where the load went wrong. A bad delay register shows in the first clock after a level change, either as a missing dead gap or as both pair outputs high together. The bench therefore compares every output against an independent model on every clock, so any of these faults is caught on the first clock it appears.

// File: rtl/cpwm_pkg.sv
// Package: shared types for the dual complementary PWM block.
// Assumes: 2-bit mode fields as listed in the brief.
package cpwm_pkg;
    typedef enum logic [1:0] {
        MODE_OFF        = 2'b00,
        MODE_CLR_PAIR   = 2'b01,
        MODE_CLR_SINGLE = 2'b10,
        MODE_SET_PAIR   = 2'b11
    } pwm_mode_e;

    localparam int unsigned NUM_CH = 2;
endpackage

// File: rtl/cpwm_timebase.sv
// Module: free-running up-counter with buffered top value and sticky overflow flag.
// Assumes: tick is a single-clock prescale strobe; writes may arrive on any clock.
module cpwm_timebase #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             top_wr,
    input  logic [CNT_W-1:0] top_wdata,
    input  logic             ovf_clr,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap,
    output logic             ovf_flag
);
    localparam logic [CNT_W-1:0] TOP_RST = {CNT_W{1'b1}};

    logic [CNT_W-1:0] top_buf;
    logic [CNT_W-1:0] top_act;
    logic             match_q;

    // Wrap event: a tick while the counter sits on the active top value.
    assign wrap = tick && (cnt == top_act);

    // Counter: advance on tick, return to zero at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (wrap)   cnt <= '0;
        else if (tick)   cnt <= cnt + 1'b1;
    end

    // Top value buffer and its copy into the active register at wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_buf <= TOP_RST;
            top_act <= TOP_RST;
        end else begin
            if (top_wr) top_buf <= top_wdata;
            if (wrap)   top_act <= top_buf;
        end
    end

    // Overflow flag: one synchronisation stage, set dominates clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_q  <= 1'b0;
            ovf_flag <= 1'b0;
        end else begin
            match_q <= wrap;
            if (match_q)      ovf_flag <= 1'b1;
            else if (ovf_clr) ovf_flag <= 1'b0;
        end
    end

    a_r2_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !tick) |=> $stable(cnt));
    a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt == '0));
    a_r9_flag_follows_match: assert property (@(posedge clk) disable iff (!rst_n)
        match_q |=> ovf_flag);
    a_r10_clear_drops_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_clr && !match_q) |=> !ovf_flag);
endmodule

// File: rtl/cpwm_deadband.sv
// Module: turns a channel level into a non-overlapping output pair.
// Assumes: rising edges wait one tick (delay register) plus one clock (output register);
//          falling edges wait only the output register.
module cpwm_deadband (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic level,
    input  logic en_p,
    input  logic en_n,
    output logic out_p,
    output logic out_n
);
    logic level_d;

    // Level delayed by one prescaled cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)    level_d <= 1'b0;
        else if (tick) level_d <= level;
    end

    // Output stage, every clock: a side is high only when current and delayed level agree.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_p <= 1'b0;
            out_n <= 1'b0;
        end else begin
            out_p <= en_p &  level &  level_d;
            out_n <= en_n & ~level & ~level_d;
        end
    end

    a_r7_pair_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_p && out_n));
    a_r8_fall_one_clk: assert property (@(posedge clk) disable iff (!rst_n)
        (!level && out_p) |=> !out_p);
endmodule

// File: rtl/cpwm_chan.sv
// Module: one PWM channel with buffered compare, level generator and dead-band pair.
// Assumes: cnt and wrap come from the shared timebase in the same clock domain.
module cpwm_chan
    import cpwm_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wrap,
    input  logic [CNT_W-1:0] cnt,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  pwm_mode_e        mode,
    output logic             out_p,
    output logic             out_n
);
    logic [CNT_W-1:0] cmp_buf;
    logic [CNT_W-1:0] cmp_act;
    logic             level;
    logic             set_on_match;
    logic             en_p;
    logic             en_n;

    assign set_on_match = (mode == MODE_SET_PAIR);
    assign en_p         = (mode != MODE_OFF);
    assign en_n         = (mode == MODE_CLR_PAIR) || (mode == MODE_SET_PAIR);

    // Compare buffer and its copy into the active register at wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_buf <= '0;
            cmp_act <= '0;
        end else begin
            if (cmp_wr) cmp_buf <= cmp_wdata;
            if (wrap)   cmp_act <= cmp_buf;
        end
    end

    // Channel level: wrap action first, compare action second.
    always_ff @(posedge clk) begin
        if (!rst_n)                          level <= 1'b0;
        else if (wrap)                       level <= ~set_on_match;
        else if (tick && (cnt == cmp_act))   level <= set_on_match;
    end

    cpwm_deadband u_deadband (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .level (level),
        .en_p  (en_p),
        .en_n  (en_n),
        .out_p (out_p),
        .out_n (out_n)
    );

    a_r6_off_low: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_OFF) |=> (!out_p && !out_n));
    a_r5_single_inv_low: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_CLR_SINGLE) |=> !out_n);
endmodule

// File: rtl/cpwm_dual.sv
// Module: top of the dual complementary dead-time PWM generator.
// Assumes: a single fast clock; tick is produced by an external prescaler.
module cpwm_dual
    import cpwm_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             top_wr,
    input  logic [CNT_W-1:0] top_wdata,
    input  logic             cmp_a_wr,
    input  logic [CNT_W-1:0] cmp_a_wdata,
    input  logic             cmp_b_wr,
    input  logic [CNT_W-1:0] cmp_b_wdata,
    input  logic [1:0]       mode_a,
    input  logic [1:0]       mode_b,
    input  logic             ovf_clr,
    output logic             ovf_flag,
    output logic             pwm_a,
    output logic             pwm_a_n,
    output logic             pwm_b,
    output logic             pwm_b_n
);
    logic [CNT_W-1:0] cnt;
    logic             wrap;

    logic             ch_wr    [NUM_CH];
    logic [CNT_W-1:0] ch_wdata [NUM_CH];
    pwm_mode_e        ch_mode  [NUM_CH];
    logic             ch_p     [NUM_CH];
    logic             ch_n     [NUM_CH];

    // Map the named channel ports onto the channel arrays.
    always_comb begin
        ch_wr[0]    = cmp_a_wr;
        ch_wr[1]    = cmp_b_wr;
        ch_wdata[0] = cmp_a_wdata;
        ch_wdata[1] = cmp_b_wdata;
        ch_mode[0]  = pwm_mode_e'(mode_a);
        ch_mode[1]  = pwm_mode_e'(mode_b);
    end

    assign pwm_a   = ch_p[0];
    assign pwm_a_n = ch_n[0];
    assign pwm_b   = ch_p[1];
    assign pwm_b_n = ch_n[1];

    cpwm_timebase #(.CNT_W(CNT_W)) u_timebase (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .top_wr    (top_wr),
        .top_wdata (top_wdata),
        .ovf_clr   (ovf_clr),
        .cnt       (cnt),
        .wrap      (wrap),
        .ovf_flag  (ovf_flag)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        cpwm_chan #(.CNT_W(CNT_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (tick),
            .wrap      (wrap),
            .cnt       (cnt),
            .cmp_wr    (ch_wr[g]),
            .cmp_wdata (ch_wdata[g]),
            .mode      (ch_mode[g]),
            .out_p     (ch_p[g]),
            .out_n     (ch_n[g])
        );
    end
endmodule

// File: tb/cpwm_dual_bench.sv
`timescale 1ns/1ps
module cpwm_dual_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       tick;
    logic       top_wr;
    logic [7:0] top_wdata;
    logic       cmp_a_wr;
    logic [7:0] cmp_a_wdata;
    logic       cmp_b_wr;
    logic [7:0] cmp_b_wdata;
    logic [1:0] mode_a;
    logic [1:0] mode_b;
    logic       ovf_clr;
    logic       ovf_flag;
    logic       pwm_a, pwm_a_n, pwm_b, pwm_b_n;

    int checks = 0;
    int fails  = 0;
    string cur_tag = "R1";
    logic  done = 1'b0;

    always #4 clk = ~clk;

    cpwm_dual u_cpwm_dual (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .top_wr(top_wr), .top_wdata(top_wdata),
        .cmp_a_wr(cmp_a_wr), .cmp_a_wdata(cmp_a_wdata),
        .cmp_b_wr(cmp_b_wr), .cmp_b_wdata(cmp_b_wdata),
        .mode_a(mode_a), .mode_b(mode_b),
        .ovf_clr(ovf_clr), .ovf_flag(ovf_flag),
        .pwm_a(pwm_a), .pwm_a_n(pwm_a_n), .pwm_b(pwm_b), .pwm_b_n(pwm_b_n)
    );

    typedef struct {
        logic [4:0] v;   // {pwm_a, pwm_a_n, pwm_b, pwm_b_n, ovf_flag}
        string      tag;
    } exp_t;
    exp_t exp_q[$];

    // Reference model state, built from the requirements.
    int   m_cnt, m_top, m_top_buf, m_match, m_flag;
    int   m_cmp[2], m_cmp_buf[2], m_lvl[2], m_lvl_d[2], m_p[2], m_n[2];
    int   n_cnt, n_top, n_top_buf, n_match, n_flag, md;
    int   n_cmp[2], n_cmp_buf[2], n_lvl[2], n_lvl_d[2], n_p[2], n_n[2];
    logic m_wrap;

    // Model: advance one clock and push the expected port values.
    always @(posedge clk) begin
        exp_t it;
        if (!rst_n) begin
            m_cnt = 0; m_top = 255; m_top_buf = 255; m_match = 0; m_flag = 0;
            for (int c = 0; c < 2; c++) begin
                m_cmp[c] = 0; m_cmp_buf[c] = 0; m_lvl[c] = 0; m_lvl_d[c] = 0; m_p[c] = 0; m_n[c] = 0;
            end
        end else begin
            m_wrap = tick && (m_cnt == m_top);
            for (int c = 0; c < 2; c++) begin
                md = (c == 0) ? int'(mode_a) : int'(mode_b);
                n_p[c] = (md != 0 && m_lvl[c] == 1 && m_lvl_d[c] == 1) ? 1 : 0;
                n_n[c] = ((md == 1 || md == 3) && m_lvl[c] == 0 && m_lvl_d[c] == 0) ? 1 : 0;
                n_lvl_d[c] = tick ? m_lvl[c] : m_lvl_d[c];
                if (m_wrap)                             n_lvl[c] = (md == 3) ? 0 : 1;
                else if (tick && m_cnt == m_cmp[c])     n_lvl[c] = (md == 3) ? 1 : 0;
                else                                    n_lvl[c] = m_lvl[c];
                n_cmp[c]     = m_wrap ? m_cmp_buf[c] : m_cmp[c];
                n_cmp_buf[c] = m_cmp_buf[c];
            end
            if (cmp_a_wr) n_cmp_buf[0] = int'(cmp_a_wdata);
            if (cmp_b_wr) n_cmp_buf[1] = int'(cmp_b_wdata);
            n_match   = m_wrap ? 1 : 0;
            n_flag    = (m_match == 1) ? 1 : (ovf_clr ? 0 : m_flag);
            n_cnt     = m_wrap ? 0 : (tick ? m_cnt + 1 : m_cnt);
            n_top     = m_wrap ? m_top_buf : m_top;
            n_top_buf = top_wr ? int'(top_wdata) : m_top_buf;
            m_cnt = n_cnt; m_top = n_top; m_top_buf = n_top_buf; m_match = n_match; m_flag = n_flag;
            for (int c = 0; c < 2; c++) begin
                m_cmp[c] = n_cmp[c]; m_cmp_buf[c] = n_cmp_buf[c]; m_lvl[c] = n_lvl[c];
                m_lvl_d[c] = n_lvl_d[c]; m_p[c] = n_p[c]; m_n[c] = n_n[c];
            end
        end
        it.v   = {m_p[0][0], m_n[0][0], m_p[1][0], m_n[1][0], m_flag[0]};
        it.tag = cur_tag;
        exp_q.push_back(it);
    end

    // Monitor: pop and compare away from the active edge.
    always @(negedge clk) begin
        exp_t it;
        logic [4:0] act;
        if (!done && exp_q.size() > 0) begin
            it  = exp_q.pop_front();
            act = {pwm_a, pwm_a_n, pwm_b, pwm_b_n, ovf_flag};
            checks++;
            if (act !== it.v) begin
                fails++;
                $display("FAIL %s: outputs {a,a_n,b,b_n,flag} actual %b expected %b at %0t",
                         it.tag, act, it.v, $time);
            end
            checks++;   // R7: never both outputs of a pair high
            if ((pwm_a && pwm_a_n) || (pwm_b && pwm_b_n)) begin
                fails++;
                $display("FAIL R7: overlapping pair actual %b expected no overlap", act);
            end
        end
    end

    task automatic check(input string tag, input int act, input int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic run(input int n, input int period);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = (i % period) == 0;
        end
    endtask

    // Count high clocks of each output over n clocks, tick every clock.
    task automatic measure(input int n, output int ha, output int han, output int hb, output int hbn);
        ha = 0; han = 0; hb = 0; hbn = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = 1'b1;
            ha += int'(pwm_a); han += int'(pwm_a_n); hb += int'(pwm_b); hbn += int'(pwm_b_n);
        end
    endtask

    task automatic write_cfg(input int top, input int ca, input int cb);
        @(negedge clk);
        top_wr = 1; top_wdata = 8'(top);
        cmp_a_wr = 1; cmp_a_wdata = 8'(ca);
        cmp_b_wr = 1; cmp_b_wdata = 8'(cb);
        @(negedge clk);
        top_wr = 0; cmp_a_wr = 0; cmp_b_wr = 0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int ha, han, hb, hbn, fl;
        rst_n = 0; tick = 0; top_wr = 0; top_wdata = 0;
        cmp_a_wr = 0; cmp_a_wdata = 0; cmp_b_wr = 0; cmp_b_wdata = 0;
        mode_a = 2'b01; mode_b = 2'b01; ovf_clr = 0;
        repeat (3) @(negedge clk);
        // R1: reset state at the ports
        check("R1", int'({pwm_a, pwm_a_n, pwm_b, pwm_b_n, ovf_flag}), 0);

        // R3: new top/compare wait for the wrap of the reset top value (255)
        cur_tag = "R3";
        rst_n = 1; mode_b = 2'b11;
        write_cfg(9, 3, 6);
        fl = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk); tick = 1; fl |= int'(ovf_flag);
        end
        check("R3", fl, 0);

        // R2/R9: run past the first wrap into the new period
        cur_tag = "R2";
        run(300, 1);
        check("R9", int'(ovf_flag), 1);

        // R8: pulse widths with a tick every clock, top 9
        cur_tag = "R8";
        measure(10, ha, han, hb, hbn);
        check("R8", ha, 3);
        check("R8", han, 5);
        check("R8", hb, 2);
        check("R8", hbn, 6);

        // R8: slower prescale, one tick every three clocks
        run(210, 3);

        // R4: compare equal to top keeps the level set; compare 0 gives narrow pulse
        cur_tag = "R4";
        mode_b = 2'b01;
        write_cfg(9, 9, 0);
        run(40, 1);
        measure(10, ha, han, hb, hbn);
        check("R4", ha, 10);
        check("R4", han, 0);
        check("R4", hb, 0);
        check("R4", hbn, 8);

        // R5/R6: true-only mode and off mode
        cur_tag = "R5";
        write_cfg(9, 4, 4);
        mode_a = 2'b10; mode_b = 2'b00;
        run(30, 1);
        measure(20, ha, han, hb, hbn);
        check("R5", han, 0);
        check("R5", ha, 8);
        check("R6", hb + hbn, 0);

        // R10: clear with ticks stopped keeps the flag low
        cur_tag = "R10";
        @(negedge clk); tick = 0; ovf_clr = 1;
        @(negedge clk); ovf_clr = 0;
        @(negedge clk); ovf_clr = 0;
        fl = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); fl |= int'(ovf_flag);
        end
        check("R10", fl, 0);

        // R9/R10: set wins over a clear held high across the top match
        cur_tag = "R9";
        @(negedge clk); ovf_clr = 1;
        run(25, 1);
        @(negedge clk); ovf_clr = 0;
        run(20, 2);
        check("R9", int'(ovf_flag), 1);

        finish_run();
    end
endmodule